// File: doc/BRIEF.md
# Load-Writeback Micro-op Cracker

This decode-stage unit receives one decoded load that also updates its base register and breaks it into an ordered series of micro-ops. The unit hands these out one per cycle over a valid/ready handshake. The load can use an immediate or a register offset and can have one or two destinations. The normal case takes two micro-ops: the memory access, then the base writeback. A third micro-op is added only when a register hazard requires it. One case is a destination that aliases the offset register; the offset is then saved in a scratch register first. The other case is a single destination equal to the PC; the load then targets the scratch register, and a final move places the value into the PC. This keeps the PC write at the very end of the sequence.

Each micro-op carries an opcode, register indices widened to 5 bits so the scratch register (index 16) can be named, the offset and shift fields passed through unchanged, a last flag, and the parent's conditional-execution state update flag. That flag is only allowed on the last micro-op. A new instruction is accepted only after the previous sequence has fully drained. Address arithmetic, shifts and memory access take place downstream.

Top module: `ldwb_cracker`

## Requirements
- R1: A load with no hazard cracks into two micro-ops: a load access (opcode 1) with the destination index, then a base writeback (opcode 2) with destination and source A equal to the base register. On both, source B is the offset register for register-offset loads and 0 for immediate-offset loads.
- R2: A single-destination register-offset load whose destination equals the offset register yields three micro-ops. First a move (opcode 0) into scratch index 16 from the offset register. Then the load access. Then the writeback, with source B equal to 16.
- R3: A dual-destination register-offset load takes the R2 three-micro-op sequence when either destination equals the offset register. Otherwise it yields two micro-ops. The load access shows the second destination on `uop_dst2` and raises `uop_dual`; `uop_dst2` is 0 for single-destination loads.
- R4: A single-destination load whose destination is the PC (index 15), with either offset kind, yields three micro-ops: a load access into index 16, the base writeback, then a move into 15 from 16. Only the final micro-op writes the PC.
- R5: When both the PC condition and the offset-alias condition hold, the PC sequence of R4 is used.
- R6: Each sequence has 2 or 3 micro-ops, and exactly one of them, the final one, has `uop_last` set.
- R7: `uop_it_upd` is set only on the last micro-op, and only when `in_it_upd` was set on the parent.
- R8: `in_ready` is high only while no micro-op is pending, so an instruction offered during a sequence is not taken. While `uop_valid` is high and `uop_ready` is low, the presented micro-op holds.
- R9: While `rst_n` is low at a clock edge, the unit returns to idle: `uop_valid` goes low and `in_ready` goes high.
- R10: On the load access and the writeback, `uop_add`, `uop_imm`, `uop_shamt`, `uop_shtype` and `uop_reg_off` equal the parent's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Parent instruction offered |
| in_ready | output | 1 | Unit idle, instruction may be taken |
| in_dual | input | 1 | Parent has two destinations |
| in_reg_off | input | 1 | Offset comes from a register |
| in_dst | input | 4 | First destination register |
| in_dst2 | input | 4 | Second destination register |
| in_base | input | 4 | Base register |
| in_idx | input | 4 | Offset register |
| in_add | input | 1 | Offset is added (else subtracted) |
| in_imm | input | 12 | Immediate offset |
| in_shamt | input | 5 | Offset shift amount |
| in_shtype | input | 2 | Offset shift kind |
| in_it_upd | input | 1 | Parent updates conditional-execution state |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_opc | output | 2 | 0 move, 1 load access, 2 base writeback |
| uop_dst | output | 5 | Destination index (16 = scratch) |
| uop_dst2 | output | 5 | Second destination of a dual load access |
| uop_src_a | output | 5 | Base source |
| uop_src_b | output | 5 | Offset or move source |
| uop_dual | output | 1 | Load access writes two registers |
| uop_reg_off | output | 1 | Offset comes from register source B |
| uop_add | output | 1 | Add/subtract offset |
| uop_imm | output | 12 | Immediate offset |
| uop_shamt | output | 5 | Shift amount |
| uop_shtype | output | 2 | Shift kind |
| uop_last | output | 1 | Final micro-op of the sequence |
| uop_it_upd | output | 1 | Apply conditional-execution state update |

## Verification
Several properties are checked on every cycle. The sequence length stays within two to three. The last flag appears exactly once per sequence. The state update flag never appears without the last flag. A PC write never comes before the final micro-op, and no sequence opens with a writeback. The handshake holds under back-pressure and no instruction is taken mid-sequence. Which of the three sequences a given register pattern selects, the scratch-register routing of offsets and results, the PC-over-alias priority, and the passthrough of the offset fields can only be shown by the bench's vector table and directed cases. Those cases compare every micro-op against the order expected for the pattern.

// File: rtl/lwb_pkg.sv
`timescale 1ns/1ps
// Shared widths, encodings and records for the load-writeback cracker.
// Assumes 16 architectural registers with the top one acting as PC.
package lwb_pkg;
    localparam int AREG_W   = 4;
    localparam int SREG_W   = AREG_W + 1;
    localparam int IMM_W    = 12;
    localparam int SHAMT_W  = 5;
    localparam int SHTYPE_W = 2;
    localparam int STEP_W   = 2;

    localparam logic [AREG_W-1:0] PC_REG      = '1;
    localparam logic [SREG_W-1:0] SCRATCH_REG = {1'b1, {AREG_W{1'b0}}};

    typedef enum logic [1:0] {
        OP_MOV  = 2'd0,
        OP_LOAD = 2'd1,
        OP_WB   = 2'd2
    } uop_op_e;

    typedef enum logic [1:0] {
        SEQ_PLAIN = 2'd0,
        SEQ_ALIAS = 2'd1,
        SEQ_PCDST = 2'd2
    } seq_kind_e;

    typedef struct packed {
        logic                dual;
        logic                reg_off;
        logic [AREG_W-1:0]   dst;
        logic [AREG_W-1:0]   dst2;
        logic [AREG_W-1:0]   base;
        logic [AREG_W-1:0]   idx;
        logic                add;
        logic [IMM_W-1:0]    imm;
        logic [SHAMT_W-1:0]  shamt;
        logic [SHTYPE_W-1:0] shtype;
        logic                it_upd;
    } ld_instr_t;

    typedef struct packed {
        uop_op_e             opc;
        logic [SREG_W-1:0]   dst;
        logic [SREG_W-1:0]   dst2;
        logic [SREG_W-1:0]   src_a;
        logic [SREG_W-1:0]   src_b;
        logic                dual;
        logic                reg_off;
        logic                add;
        logic [IMM_W-1:0]    imm;
        logic [SHAMT_W-1:0]  shamt;
        logic [SHTYPE_W-1:0] shtype;
        logic                last;
        logic                it_upd;
    } uop_t;
endpackage

// File: rtl/lwb_hazard_check.sv
`timescale 1ns/1ps
// Classifies a parent load by register hazard into one of three sequences.
// Assumes the PC check applies to single-destination loads only and wins
// over the offset-alias check.
module lwb_hazard_check
    import lwb_pkg::*;
(
    input  logic              dual,
    input  logic              reg_off,
    input  logic [AREG_W-1:0] dst,
    input  logic [AREG_W-1:0] dst2,
    input  logic [AREG_W-1:0] idx,
    output seq_kind_e         kind
);
    logic pc_hit;
    logic alias_hit;

    // Detect the two hazards and pick the sequence, PC first.
    always_comb begin
        pc_hit    = !dual && (dst == PC_REG);
        alias_hit = reg_off && ((dst == idx) || (dual && (dst2 == idx)));
        if (pc_hit)
            kind = SEQ_PCDST;
        else if (alias_hit)
            kind = SEQ_ALIAS;
        else
            kind = SEQ_PLAIN;
    end
endmodule

// File: rtl/lwb_sequencer.sv
`timescale 1ns/1ps
// Step counter for one cracked sequence. Accepts a parent only when idle,
// so one idle cycle separates sequences; advances on each output handshake.
module lwb_sequencer
    import lwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              accept,
    input  seq_kind_e         kind_in,
    output seq_kind_e         kind_q,
    output logic [STEP_W-1:0] step,
    output logic              is_last,
    output logic              uop_valid,
    input  logic              uop_ready
);
    logic              busy;
    logic [STEP_W-1:0] final_step;

    // Index of the final step for the captured sequence kind.
    always_comb begin
        final_step = (kind_q == SEQ_PLAIN) ? STEP_W'(1) : STEP_W'(2);
        is_last    = (step == final_step);
        in_ready   = !busy;
        accept     = in_valid && !busy;
        uop_valid  = busy;
    end

    // Capture kind on accept, walk the steps, return idle after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            step   <= '0;
            kind_q <= SEQ_PLAIN;
        end else if (accept) begin
            busy   <= 1'b1;
            step   <= '0;
            kind_q <= kind_in;
        end else if (busy && uop_ready) begin
            if (is_last) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/lwb_uop_builder.sv
`timescale 1ns/1ps
// Builds the micro-op for the current step from the held parent and kind.
// Fields not used by a micro-op's role are driven to zero.
module lwb_uop_builder
    import lwb_pkg::*;
(
    input  ld_instr_t         ins,
    input  seq_kind_e         kind,
    input  logic [STEP_W-1:0] step,
    input  logic              last,
    output uop_t              uop
);
    typedef enum logic [1:0] {
        ROLE_COPY,
        ROLE_LOAD,
        ROLE_WB,
        ROLE_PCMOV
    } role_e;

    role_e             role;
    logic [SREG_W-1:0] off_src;

    // Map (kind, step) to the role of the current micro-op.
    always_comb begin
        unique case (kind)
            SEQ_ALIAS: role = (step == '0) ? ROLE_COPY :
                              (step == STEP_W'(1)) ? ROLE_LOAD : ROLE_WB;
            SEQ_PCDST: role = (step == '0) ? ROLE_LOAD :
                              (step == STEP_W'(1)) ? ROLE_WB : ROLE_PCMOV;
            default:   role = (step == '0) ? ROLE_LOAD : ROLE_WB;
        endcase
    end

    // Fill the micro-op record for the chosen role.
    always_comb begin
        off_src = ins.reg_off ? {1'b0, ins.idx} : '0;
        uop     = '0;
        unique case (role)
            ROLE_COPY: begin
                uop.opc   = OP_MOV;
                uop.dst   = SCRATCH_REG;
                uop.src_b = {1'b0, ins.idx};
            end
            ROLE_LOAD: begin
                uop.opc     = OP_LOAD;
                uop.dst     = (kind == SEQ_PCDST) ? SCRATCH_REG : {1'b0, ins.dst};
                uop.dst2    = ins.dual ? {1'b0, ins.dst2} : '0;
                uop.dual    = ins.dual;
                uop.src_a   = {1'b0, ins.base};
                uop.src_b   = off_src;
                uop.reg_off = ins.reg_off;
                uop.add     = ins.add;
                uop.imm     = ins.imm;
                uop.shamt   = ins.shamt;
                uop.shtype  = ins.shtype;
            end
            ROLE_WB: begin
                uop.opc     = OP_WB;
                uop.dst     = {1'b0, ins.base};
                uop.src_a   = {1'b0, ins.base};
                uop.src_b   = (kind == SEQ_ALIAS) ? SCRATCH_REG : off_src;
                uop.reg_off = ins.reg_off;
                uop.add     = ins.add;
                uop.imm     = ins.imm;
                uop.shamt   = ins.shamt;
                uop.shtype  = ins.shtype;
            end
            default: begin
                uop.opc   = OP_MOV;
                uop.dst   = {1'b0, PC_REG};
                uop.src_b = SCRATCH_REG;
            end
        endcase
        uop.last   = last;
        uop.it_upd = ins.it_upd && last;
    end
endmodule

// File: rtl/ldwb_cracker.sv
`timescale 1ns/1ps
// Top of the load-writeback cracker: holds the accepted parent load,
// classifies it, and emits its micro-ops one per handshake.
// Assumes the consumer obeys valid/ready; no input buffering is provided.
module ldwb_cracker
    import lwb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_dual,
    input  logic                in_reg_off,
    input  logic [AREG_W-1:0]   in_dst,
    input  logic [AREG_W-1:0]   in_dst2,
    input  logic [AREG_W-1:0]   in_base,
    input  logic [AREG_W-1:0]   in_idx,
    input  logic                in_add,
    input  logic [IMM_W-1:0]    in_imm,
    input  logic [SHAMT_W-1:0]  in_shamt,
    input  logic [SHTYPE_W-1:0] in_shtype,
    input  logic                in_it_upd,
    output logic                uop_valid,
    input  logic                uop_ready,
    output logic [1:0]          uop_opc,
    output logic [SREG_W-1:0]   uop_dst,
    output logic [SREG_W-1:0]   uop_dst2,
    output logic [SREG_W-1:0]   uop_src_a,
    output logic [SREG_W-1:0]   uop_src_b,
    output logic                uop_dual,
    output logic                uop_reg_off,
    output logic                uop_add,
    output logic [IMM_W-1:0]    uop_imm,
    output logic [SHAMT_W-1:0]  uop_shamt,
    output logic [SHTYPE_W-1:0] uop_shtype,
    output logic                uop_last,
    output logic                uop_it_upd
);
    ld_instr_t         ins_d;
    ld_instr_t         ins_q;
    seq_kind_e         kind_d;
    seq_kind_e         kind_q;
    logic              accept;
    logic [STEP_W-1:0] step;
    logic              is_last;
    uop_t              uop;

    // Pack the parent fields into one record.
    always_comb begin
        ins_d = '{dual: in_dual, reg_off: in_reg_off, dst: in_dst,
                  dst2: in_dst2, base: in_base, idx: in_idx, add: in_add,
                  imm: in_imm, shamt: in_shamt, shtype: in_shtype,
                  it_upd: in_it_upd};
    end

    lwb_hazard_check u_hazard (
        .dual    (in_dual),
        .reg_off (in_reg_off),
        .dst     (in_dst),
        .dst2    (in_dst2),
        .idx     (in_idx),
        .kind    (kind_d)
    );

    lwb_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .accept    (accept),
        .kind_in   (kind_d),
        .kind_q    (kind_q),
        .step      (step),
        .is_last   (is_last),
        .uop_valid (uop_valid),
        .uop_ready (uop_ready)
    );

    // Hold the accepted parent for the life of its sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ins_q <= '0;
        else if (accept)
            ins_q <= ins_d;
    end

    lwb_uop_builder u_build (
        .ins  (ins_q),
        .kind (kind_q),
        .step (step),
        .last (is_last),
        .uop  (uop)
    );

    // Spread the micro-op record onto the output ports.
    always_comb begin
        uop_opc     = uop.opc;
        uop_dst     = uop.dst;
        uop_dst2    = uop.dst2;
        uop_src_a   = uop.src_a;
        uop_src_b   = uop.src_b;
        uop_dual    = uop.dual;
        uop_reg_off = uop.reg_off;
        uop_add     = uop.add;
        uop_imm     = uop.imm;
        uop_shamt   = uop.shamt;
        uop_shtype  = uop.shtype;
        uop_last    = uop.last;
        uop_it_upd  = uop.it_upd;
    end
endmodule

// File: rtl/lwb_checker.sv
`timescale 1ns/1ps
// Protocol and ordering properties for the cracker, attached by bind.
module lwb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       uop_valid,
    input logic       uop_ready,
    input logic [1:0] uop_opc,
    input logic [4:0] uop_dst,
    input logic [4:0] uop_src_b,
    input logic       uop_dual,
    input logic       uop_last,
    input logic       uop_it_upd
);
    logic [1:0] seen;

    // Count micro-ops handed out in the current sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (uop_valid && uop_ready)
            seen <= uop_last ? 2'd0 : seen + 2'd1;
    end

    p_len_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> seen <= 2'd2);
    p_len_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_last |-> seen >= 2'd1);
    p_third_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && seen == 2'd2 |-> uop_last);
    p_it_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uop_it_upd |-> uop_valid && uop_last);
    p_pc_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_dst == 5'd15 &&
        (uop_opc == 2'd0 || (uop_opc == 2'd1 && !uop_dual)) |-> uop_last);
    p_opc_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> uop_opc != 2'd3);
    p_first_not_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && seen == 2'd0 |-> uop_opc != 2'd2);
    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && uop_valid));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_opc) &&
        $stable(uop_dst) && $stable(uop_src_b) && $stable(uop_last));
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && uop_last |=> !uop_valid);
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !uop_valid && in_ready);
endmodule

bind ldwb_cracker lwb_checker u_lwb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .uop_valid  (uop_valid),
    .uop_ready  (uop_ready),
    .uop_opc    (uop_opc),
    .uop_dst    (uop_dst),
    .uop_src_b  (uop_src_b),
    .uop_dual   (uop_dual),
    .uop_last   (uop_last),
    .uop_it_upd (uop_it_upd)
);

// File: tb/test_ldwb_cracker.sv
`timescale 1ns/1ps
module test_ldwb_cracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_dual = 1'b0;
    logic        in_reg_off = 1'b0;
    logic [3:0]  in_dst = '0;
    logic [3:0]  in_dst2 = '0;
    logic [3:0]  in_base = '0;
    logic [3:0]  in_idx = '0;
    logic        in_add = 1'b0;
    logic [11:0] in_imm = '0;
    logic [4:0]  in_shamt = '0;
    logic [1:0]  in_shtype = '0;
    logic        in_it_upd = 1'b0;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [1:0]  uop_opc;
    logic [4:0]  uop_dst;
    logic [4:0]  uop_dst2;
    logic [4:0]  uop_src_a;
    logic [4:0]  uop_src_b;
    logic        uop_dual;
    logic        uop_reg_off;
    logic        uop_add;
    logic [11:0] uop_imm;
    logic [4:0]  uop_shamt;
    logic [1:0]  uop_shtype;
    logic        uop_last;
    logic        uop_it_upd;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldwb_cracker i_ldwb_cracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dual(in_dual), .in_reg_off(in_reg_off), .in_dst(in_dst),
        .in_dst2(in_dst2), .in_base(in_base), .in_idx(in_idx),
        .in_add(in_add), .in_imm(in_imm), .in_shamt(in_shamt),
        .in_shtype(in_shtype), .in_it_upd(in_it_upd),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_opc(uop_opc),
        .uop_dst(uop_dst), .uop_dst2(uop_dst2), .uop_src_a(uop_src_a),
        .uop_src_b(uop_src_b), .uop_dual(uop_dual),
        .uop_reg_off(uop_reg_off), .uop_add(uop_add), .uop_imm(uop_imm),
        .uop_shamt(uop_shamt), .uop_shtype(uop_shtype),
        .uop_last(uop_last), .uop_it_upd(uop_it_upd)
    );

    // Vector: {dual, reg_off, it_upd, dst, dst2, base, idx, kind}
    // kind 0 = two micro-ops, 1 = offset-alias copy first, 2 = PC destination
    localparam logic [20:0] TBL [0:10] = '{
        {1'b0, 1'b0, 1'b1, 4'd3,  4'd0, 4'd2, 4'd0,  2'd0},  // R1 imm
        {1'b0, 1'b1, 1'b0, 4'd3,  4'd0, 4'd2, 4'd5,  2'd0},  // R1 reg
        {1'b0, 1'b1, 1'b1, 4'd5,  4'd0, 4'd2, 4'd5,  2'd1},  // R2
        {1'b1, 1'b1, 1'b0, 4'd4,  4'd6, 4'd1, 4'd6,  2'd1},  // R3 second dst
        {1'b1, 1'b1, 1'b1, 4'd6,  4'd7, 4'd1, 4'd6,  2'd1},  // R3 first dst
        {1'b1, 1'b1, 1'b0, 4'd8,  4'd9, 4'd1, 4'd6,  2'd0},  // R3 no match
        {1'b0, 1'b0, 1'b1, 4'd15, 4'd0, 4'd13, 4'd0, 2'd2},  // R4 imm
        {1'b0, 1'b1, 1'b0, 4'd15, 4'd0, 4'd13, 4'd15, 2'd2}, // R5 both hit
        {1'b0, 1'b1, 1'b1, 4'd15, 4'd0, 4'd4, 4'd3,  2'd2},  // R4 reg
        {1'b1, 1'b0, 1'b0, 4'd6,  4'd7, 4'd1, 4'd6,  2'd0},  // R3 imm dual
        {1'b0, 1'b0, 1'b0, 4'd9,  4'd0, 4'd1, 4'd9,  2'd0}   // R1 imm idx ignored
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected {opc, dst, src_b} per kind and step, from R1, R2 and R4.
    function automatic logic [11:0] expect_uop(input logic [20:0] e, input int s);
        logic [4:0] dst, base, idx, off;
        dst  = {1'b0, e[17:14]};
        base = {1'b0, e[9:6]};
        idx  = {1'b0, e[5:2]};
        off  = e[19] ? idx : 5'd0;
        case (e[1:0])
            2'd1: case (s)
                0: return {2'd0, 5'd16, idx};
                1: return {2'd1, dst, idx};
                default: return {2'd2, base, 5'd16};
            endcase
            2'd2: case (s)
                0: return {2'd1, 5'd16, off};
                1: return {2'd2, base, off};
                default: return {2'd0, 5'd15, 5'd16};
            endcase
            default: return (s == 0) ? {2'd1, dst, off} : {2'd2, base, off};
        endcase
    endfunction

    task automatic drive(input logic [20:0] e, input int k);
        in_dual    = e[20];
        in_reg_off = e[19];
        in_it_upd  = e[18];
        in_dst     = e[17:14];
        in_dst2    = e[13:10];
        in_base    = e[9:6];
        in_idx     = e[5:2];
        in_add     = k[0];
        in_imm     = 12'h100 + 12'(k);
        in_shamt   = 5'(k + 1);
        in_shtype  = 2'(k);
    endtask

    task automatic run_vec(input logic [20:0] e, input int k, input bit stall);
        int len;
        logic [11:0] ex;
        len = (e[1:0] == 2'd0) ? 2 : 3;
        @(negedge clk);
        drive(e, k);
        in_valid  = 1'b1;
        uop_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        for (int s = 0; s < len; s++) begin
            ex = expect_uop(e, s);
            if (stall) begin
                @(negedge clk);
                check(uop_valid == 1'b1, "R8 hold valid", uop_valid, 1);
            end
            check(uop_valid == 1'b1, "R6 valid", uop_valid, 1);
            check(uop_opc == ex[11:10], "R1/R2/R4 opcode", uop_opc, ex[11:10]);
            check(uop_dst == ex[9:5], "R1/R2/R4/R5 dst", uop_dst, ex[9:5]);
            check(uop_src_b == ex[4:0], "R1/R2/R4 src_b", uop_src_b, ex[4:0]);
            check(uop_last == (s == len - 1), "R6 last", uop_last, s == len - 1);
            check(uop_it_upd == (e[18] && s == len - 1), "R7 it_upd",
                  uop_it_upd, e[18] && s == len - 1);
            check(in_ready == 1'b0, "R8 busy", in_ready, 0);
            if (ex[11:10] != 2'd0) begin
                check(uop_src_a == {1'b0, e[9:6]}, "R1 src_a", uop_src_a, e[9:6]);
                check(uop_imm == 12'h100 + 12'(k), "R10 imm", uop_imm, 12'h100 + k);
                check(uop_shamt == 5'(k + 1) && uop_shtype == 2'(k) &&
                      uop_add == k[0] && uop_reg_off == e[19],
                      "R10 shift/add", uop_shamt, k + 1);
            end
            if (ex[11:10] == 2'd1) begin
                check(uop_dual == e[20], "R3 dual", uop_dual, e[20]);
                check(uop_dst2 == (e[20] ? {1'b0, e[13:10]} : 5'd0), "R3 dst2",
                      uop_dst2, e[20] ? e[13:10] : 0);
            end
            uop_ready = 1'b1;
            @(negedge clk);
            uop_ready = 1'b0;
        end
        check(uop_valid == 1'b0 && in_ready == 1'b1, "R6 drained", uop_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(uop_valid == 1'b0, "R9 reset valid", uop_valid, 0);
        check(in_ready == 1'b1, "R9 reset ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 11; i++)
            run_vec(TBL[i], i, i[0]);

        // R8: an offer during a sequence waits for the drain.
        @(negedge clk);
        drive(TBL[1], 3);
        in_valid = 1'b1;
        @(negedge clk);
        in_dst = 4'd15;
        in_reg_off = 1'b0;
        check(in_ready == 1'b0, "R8 not ready while busy", in_ready, 0);
        check(uop_opc == 2'd1 && uop_dst == 5'd3, "R8 first uop", uop_dst, 3);
        uop_ready = 1'b1;
        @(negedge clk);
        check(uop_opc == 2'd2 && uop_last, "R8 writeback uop", uop_opc, 2);
        @(negedge clk);
        uop_ready = 1'b0;
        check(uop_valid == 1'b0 && in_ready == 1'b1, "R8 idle gap", uop_valid, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check(uop_valid && uop_opc == 2'd1 && uop_dst == 5'd16,
              "R4 next parent taken after drain", uop_dst, 16);
        uop_ready = 1'b1;
        repeat (3) @(negedge clk);
        uop_ready = 1'b0;
        check(uop_valid == 1'b0, "R6 three-step drain", uop_valid, 0);

        // R9: reset in the middle of a sequence.
        drive(TBL[2], 0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(uop_valid == 1'b1, "R2 started", uop_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(uop_valid == 1'b0 && in_ready == 1'b1, "R9 mid-sequence reset",
              uop_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(uop_valid == 1'b0, "R9 stays idle", uop_valid, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule